// File: doc/BRIEF.md
# Prefixed Opcode Addressing Decoder

This block watches an incoming instruction byte stream for an 8-bit processor and classifies each instruction as it passes. An instruction may start with one prefix byte (hex 72, 90, 91 or 92). An opcode byte follows. After the opcode come zero to two operand bytes. The decoder tracks where each instruction starts. It consumes and discards the operand bytes, so that it never mistakes them for opcodes. For every opcode it emits one record: the addressing mode, the index register, the 16-bit register operand, whether the operand address goes through a pointer in memory and how wide that pointer's address is, how many operand bytes follow, the total length of the instruction, and the operation field with a flag telling whether it is an accumulator-type operation.

The opcode's high nibble gives the base addressing mode. A prefix then changes how that mode is read:
- One prefix exchanges the X and Y roles.
- Two prefixes turn an absolute or offset operand into a one-byte address of a 16-bit pointer. One of these two also moves indexing to Y.
- A fourth prefix gives pointer forms whose pointer has a 16-bit address. On the opcode groups where it does not give those forms, it takes the opcode out of the accumulator-operation space entirely.

A second prefix in a row is reported as an illegal instruction, and decoding restarts on the byte that follows it. The decoder sits beside a fetch unit. It consumes one byte per cycle when `in_valid` is high.

Top module: `ad_decoder`

## Requirements
- R1: With no prefix, the opcode high nibble sets the mode and the operand count. The codes on `out_mode` are: 1=1 (code 1, stack-relative 8-bit offset, index SP, 1 byte), A=2 (immediate, 1 byte), B=3 (8-bit absolute, 1 byte), C=4 (16-bit absolute, 2 bytes), D=5 (16-bit offset plus index X, 2 bytes), E=6 (8-bit offset plus index X, 1 byte), F=7 (index X only, 0 bytes). The codes on `out_index` are 0 none, 1 X, 2 Y, 3 SP.
- R2: `out_alu_op` carries opcode bits 3:0, and `out_alu_vld` is 1 for the nibbles listed in R1. Every other high nibble gives mode 0 (unclassified), index none, `out_alu_vld`=0 and 0 operand bytes.
- R3: Prefix 90 turns index X into Y and inverts `out_wreg_y`. It leaves mode, operand count and SP indexing unchanged.
- R4: Prefix 92 on nibble C or D sets `out_indirect`=1 with `out_ptr_a16`=0 and 1 operand byte. Nibble D keeps index X. On any other nibble, prefix 92 gives an unclassified record.
- R5: Prefix 91 on nibble D gives the same pointer form as R4, but with index Y and `out_wreg_y` inverted. On any other nibble, prefix 91 gives an unclassified record.
- R6: Prefix 72 on nibble C or D sets `out_indirect`=1 and `out_ptr_a16`=1, keeps 2 operand bytes and keeps index X on D. On any other nibble, prefix 72 gives an unclassified record with `out_alu_vld`=0 and 0 operand bytes.
- R7: With no prefix, `out_wreg_y` is 1 exactly when the operation field is 3, E or F and the mode is indexed by X (nibbles D, E, F). Unclassified records report 0.
- R8: `out_len` equals 1 for the opcode, plus 1 if there was a prefix, plus the operand count.
- R9: The operand bytes that follow an opcode are consumed without being decoded, even when they look like prefixes. Bytes presented while `in_valid` is low are ignored.
- R10: A prefix directly after a prefix gives a record with `out_illegal`=1, mode 0, length 2, 0 operand bytes and `out_alu_vld`=0. The next byte is decoded as the start of a new instruction.
- R11: Each record appears with `out_valid` high for exactly one cycle, on the cycle after the opcode byte is accepted. Prefix and operand bytes raise no strobe. Reset clears the strobe and any pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Record strobe, one cycle |
| out_mode | output | 3 | Addressing mode code (R1), 0 = unclassified |
| out_index | output | 2 | Index register: 0 none, 1 X, 2 Y, 3 SP |
| out_wreg_y | output | 1 | 16-bit register operand is Y (1) or X (0) |
| out_indirect | output | 1 | Operand address comes through a pointer in memory |
| out_ptr_a16 | output | 1 | The pointer's own address is 16 bits wide |
| out_opnd | output | 3 | Operand bytes following the opcode |
| out_len | output | 3 | Total instruction length in bytes |
| out_alu_op | output | 4 | Operation field, opcode bits 3:0 |
| out_alu_vld | output | 1 | Operation field names an accumulator-type operation |
| out_illegal | output | 1 | Two prefixes in a row |

## Verification
A vector table presents every classified high nibble without a prefix. It then presents each prefix against nibbles where the prefix applies and nibbles where it does not. This separates the base mode table from the prefix rewrites, and it separates the 8-bit pointer address from the 16-bit one. Operand bytes are filled with prefix-valued bytes, so a decoder that skips the wrong number of bytes desynchronises on the next vector. Directed sequences cover two prefixes in a row followed by resynchronisation, idle cycles that carry prefix-looking data, and a reset taken between a prefix and its opcode.

// File: rtl/ad_pkg.sv
package ad_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_OPND = 4;
    localparam int CNT_W    = $clog2(MAX_OPND + 1);
    localparam int LEN_W    = $clog2(MAX_OPND + 3);

    typedef enum logic [2:0] {
        AM_OTHER     = 3'd0,
        AM_SP_OFF8   = 3'd1,
        AM_IMM8      = 3'd2,
        AM_ABS8      = 3'd3,
        AM_ABS16     = 3'd4,
        AM_IDX_OFF16 = 3'd5,
        AM_IDX_OFF8  = 3'd6,
        AM_IDX_ONLY  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_X    = 2'd1,
        IX_Y    = 2'd2,
        IX_SP   = 2'd3
    } index_e;

    typedef enum logic [2:0] {
        PF_NONE = 3'd0,
        PF_WIDE = 3'd1,   // 72: 16-bit-addressed pointer forms, reassignment
        PF_SWAP = 3'd2,   // 90: X/Y exchange
        PF_PTRY = 3'd3,   // 91: 8-bit pointer address, Y index
        PF_PTRX = 3'd4    // 92: 8-bit pointer address
    } prefix_e;

    typedef struct packed {
        amode_e            mode;
        index_e            idx;
        logic              wreg_y;
        logic              ind;
        logic              ptr_a16;
        logic [CNT_W-1:0]  opnd;
        logic [LEN_W-1:0]  len;
        logic [3:0]        alu;
        logic              alu_vld;
        logic              illegal;
    } drec_t;

    function automatic prefix_e prefix_of(input logic [BYTE_W-1:0] b);
        case (b)
            8'h72:   return PF_WIDE;
            8'h90:   return PF_SWAP;
            8'h91:   return PF_PTRY;
            8'h92:   return PF_PTRX;
            default: return PF_NONE;
        endcase
    endfunction

    function automatic drec_t illegal_rec();
        drec_t r;
        r         = '0;
        r.mode    = AM_OTHER;
        r.idx     = IX_NONE;
        r.len     = LEN_W'(2);
        r.illegal = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ad_classify.sv
module ad_classify
    import ad_pkg::*;
(
    input  prefix_e            pfx,
    input  logic [BYTE_W-1:0]  op,
    output drec_t              rec
);

    logic indexed;
    logic word_op;
    logic demote;
    drec_t r;

    always_comb begin
        r       = '0;
        r.mode  = AM_OTHER;
        r.idx   = IX_NONE;
        r.alu   = op[3:0];
        indexed = 1'b0;
        demote  = 1'b0;

        // base mode from the high nibble
        case (op[7:4])
            4'h1: begin r.mode = AM_SP_OFF8;   r.idx = IX_SP; r.opnd = CNT_W'(1); end
            4'hA: begin r.mode = AM_IMM8;                     r.opnd = CNT_W'(1); end
            4'hB: begin r.mode = AM_ABS8;                     r.opnd = CNT_W'(1); end
            4'hC: begin r.mode = AM_ABS16;                    r.opnd = CNT_W'(2); end
            4'hD: begin r.mode = AM_IDX_OFF16; r.idx = IX_X;  r.opnd = CNT_W'(2); indexed = 1'b1; end
            4'hE: begin r.mode = AM_IDX_OFF8;  r.idx = IX_X;  r.opnd = CNT_W'(1); indexed = 1'b1; end
            4'hF: begin r.mode = AM_IDX_ONLY;  r.idx = IX_X;  r.opnd = CNT_W'(0); indexed = 1'b1; end
            default: ;
        endcase

        word_op  = (op[3:0] == 4'h3) || (op[3:0] == 4'hE) || (op[3:0] == 4'hF);
        r.wreg_y = indexed && word_op;

        // prefix rewrite
        case (pfx)
            PF_SWAP: begin
                if (r.mode != AM_OTHER) begin
                    if (r.idx == IX_X) r.idx = IX_Y;
                    r.wreg_y = !r.wreg_y;
                end
            end
            PF_PTRX: begin
                if (r.mode == AM_ABS16 || r.mode == AM_IDX_OFF16) begin
                    r.ind  = 1'b1;
                    r.opnd = CNT_W'(1);
                end else begin
                    demote = 1'b1;
                end
            end
            PF_PTRY: begin
                if (r.mode == AM_IDX_OFF16) begin
                    r.ind    = 1'b1;
                    r.opnd   = CNT_W'(1);
                    r.idx    = IX_Y;
                    r.wreg_y = !r.wreg_y;
                end else begin
                    demote = 1'b1;
                end
            end
            PF_WIDE: begin
                if (r.mode == AM_ABS16 || r.mode == AM_IDX_OFF16) begin
                    r.ind     = 1'b1;
                    r.ptr_a16 = 1'b1;
                end else begin
                    demote = 1'b1;
                end
            end
            default: ;
        endcase

        if (demote) r.mode = AM_OTHER;

        if (r.mode == AM_OTHER) begin
            r.idx     = IX_NONE;
            r.wreg_y  = 1'b0;
            r.ind     = 1'b0;
            r.ptr_a16 = 1'b0;
            r.opnd    = '0;
        end

        r.alu_vld = (r.mode != AM_OTHER);
        r.len     = LEN_W'(1) + LEN_W'(pfx != PF_NONE) + LEN_W'(r.opnd);
    end

    assign rec = r;

endmodule

// File: rtl/ad_stream_fsm.sv
module ad_stream_fsm
    import ad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  drec_t              rec,
    output prefix_e            pfx_q,
    output logic               out_valid,
    output drec_t              out_rec
);

    typedef enum logic [1:0] {S_OPC, S_PFX, S_SKIP} st_e;

    st_e              state;
    logic [CNT_W-1:0] cnt;
    prefix_e          byte_pfx;

    assign byte_pfx = prefix_of(in_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_OPC;
            pfx_q     <= PF_NONE;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_rec   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                case (state)
                    S_SKIP: begin
                        cnt <= cnt - CNT_W'(1);
                        if (cnt == CNT_W'(1)) state <= S_OPC;
                    end
                    S_PFX: begin
                        pfx_q     <= PF_NONE;
                        out_valid <= 1'b1;
                        if (byte_pfx != PF_NONE) begin
                            out_rec <= illegal_rec();
                            state   <= S_OPC;
                        end else begin
                            out_rec <= rec;
                            cnt     <= rec.opnd;
                            state   <= (rec.opnd != '0) ? S_SKIP : S_OPC;
                        end
                    end
                    default: begin
                        if (byte_pfx != PF_NONE) begin
                            pfx_q <= byte_pfx;
                            state <= S_PFX;
                        end else begin
                            out_valid <= 1'b1;
                            out_rec   <= rec;
                            cnt       <= rec.opnd;
                            state     <= (rec.opnd != '0) ? S_SKIP : S_OPC;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ad_decoder.sv
module ad_decoder
    import ad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [2:0]        out_mode,
    output logic [1:0]        out_index,
    output logic              out_wreg_y,
    output logic              out_indirect,
    output logic              out_ptr_a16,
    output logic [2:0]        out_opnd,
    output logic [2:0]        out_len,
    output logic [3:0]        out_alu_op,
    output logic              out_alu_vld,
    output logic              out_illegal
);

    prefix_e pfx_q;
    drec_t   rec;
    drec_t   held;

    ad_classify u_cls (
        .pfx (pfx_q),
        .op  (in_byte),
        .rec (rec)
    );

    ad_stream_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .rec       (rec),
        .pfx_q     (pfx_q),
        .out_valid (out_valid),
        .out_rec   (held)
    );

    assign out_mode     = held.mode;
    assign out_index    = held.idx;
    assign out_wreg_y   = held.wreg_y;
    assign out_indirect = held.ind;
    assign out_ptr_a16  = held.ptr_a16;
    assign out_opnd     = 3'(held.opnd);
    assign out_len      = 3'(held.len);
    assign out_alu_op   = held.alu;
    assign out_alu_vld  = held.alu_vld;
    assign out_illegal  = held.illegal;

endmodule

module ad_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_valid,
    input logic [2:0] out_mode,
    input logic [1:0] out_index,
    input logic       out_wreg_y,
    input logic       out_indirect,
    input logic       out_ptr_a16,
    input logic [2:0] out_opnd,
    input logic [2:0] out_len,
    input logic [3:0] out_alu_op,
    input logic       out_alu_vld,
    input logic       out_illegal
);

    p_ill_shape_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_illegal |-> out_len == 3'd2 && out_opnd == 3'd0 && out_mode == 3'd0
                                     && !out_alu_vld && out_alu_op == 4'd0);

    p_ind_mode_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_indirect |-> (out_mode == 3'd4 || out_mode == 3'd5));

    p_ptr8_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_indirect && !out_ptr_a16 |-> out_opnd == 3'd1);

    p_ptr16_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ptr_a16 |-> out_indirect && out_opnd == 3'd2);

    p_skip_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_opnd != 3'd0 |=> !out_valid);

    p_sp_mode_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_index == 2'd3 |-> out_mode == 3'd1);

    p_other_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_mode == 3'd0 |-> !out_alu_vld && out_index == 2'd0 && !out_wreg_y);

    p_cause_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

bind ad_decoder ad_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_mode     (out_mode),
    .out_index    (out_index),
    .out_wreg_y   (out_wreg_y),
    .out_indirect (out_indirect),
    .out_ptr_a16  (out_ptr_a16),
    .out_opnd     (out_opnd),
    .out_len      (out_len),
    .out_alu_op   (out_alu_op),
    .out_alu_vld  (out_alu_vld),
    .out_illegal  (out_illegal)
);

// File: tb/sim_ad_decoder.sv
`timescale 1ns/1ps
module sim_ad_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [2:0] out_mode;
    logic [1:0] out_index;
    logic       out_wreg_y;
    logic       out_indirect;
    logic       out_ptr_a16;
    logic [2:0] out_opnd;
    logic [2:0] out_len;
    logic [3:0] out_alu_op;
    logic       out_alu_vld;
    logic       out_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ad_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_mode(out_mode), .out_index(out_index),
        .out_wreg_y(out_wreg_y), .out_indirect(out_indirect), .out_ptr_a16(out_ptr_a16),
        .out_opnd(out_opnd), .out_len(out_len), .out_alu_op(out_alu_op),
        .out_alu_vld(out_alu_vld), .out_illegal(out_illegal)
    );

    // entry: {req[3:0], prefix[7:0] (00 = none), opcode[7:0], expected[14:0]}
    // expected: {mode[2:0], index[1:0], wreg_y, indirect, ptr_a16, opnd[2:0], len[2:0], alu_vld}
    function automatic logic [34:0] mk(input logic [3:0] req, input logic [7:0] pre,
                                       input logic [7:0] op, input logic [2:0] m,
                                       input logic [1:0] ix, input logic w, input logic ind,
                                       input logic p16, input logic [2:0] n,
                                       input logic [2:0] l, input logic a);
        return {req, pre, op, m, ix, w, ind, p16, n, l, a};
    endfunction

    localparam int NV = 21;
    localparam logic [34:0] VEC [NV] = '{
        mk(4'd1, 8'h00, 8'h1B, 3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b1), // R1 stack-relative
        mk(4'd1, 8'h00, 8'hA9, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b1), // R1 immediate
        mk(4'd1, 8'h00, 8'hB6, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b1), // R1 abs8
        mk(4'd1, 8'h00, 8'hC6, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd3, 1'b1), // R1 abs16
        mk(4'd1, 8'h00, 8'hD6, 3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd3, 1'b1), // R1 off16+X
        mk(4'd7, 8'h00, 8'hE3, 3'd6, 2'd1, 1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 1'b1), // R7 word compare, X index
        mk(4'd7, 8'h00, 8'hFE, 3'd7, 2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd1, 1'b1), // R7 word load, X index
        mk(4'd2, 8'h00, 8'h9D, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0), // R2 unclassified
        mk(4'd3, 8'h90, 8'hFE, 3'd7, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b1), // R3 swap
        mk(4'd3, 8'h90, 8'hE6, 3'd6, 2'd2, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 1'b1), // R3 swap
        mk(4'd4, 8'h92, 8'hC6, 3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd3, 1'b1), // R4 [addr8]
        mk(4'd4, 8'h92, 8'hD6, 3'd5, 2'd1, 1'b0, 1'b1, 1'b0, 3'd1, 3'd3, 1'b1), // R4 [addr8],X
        mk(4'd5, 8'h91, 8'hDE, 3'd5, 2'd2, 1'b0, 1'b1, 1'b0, 3'd1, 3'd3, 1'b1), // R5 [addr8],Y
        mk(4'd6, 8'h72, 8'hCB, 3'd4, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd4, 1'b1), // R6 [addr16]
        mk(4'd6, 8'h72, 8'hDB, 3'd5, 2'd1, 1'b0, 1'b1, 1'b1, 3'd2, 3'd4, 1'b1), // R6 [addr16],X
        mk(4'd6, 8'h72, 8'hA9, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0), // R6 reassigned
        mk(4'd4, 8'h92, 8'hA6, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0), // R4 other nibble
        mk(4'd8, 8'h90, 8'h9D, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0), // R8 prefix counted
        mk(4'd3, 8'h90, 8'h13, 3'd1, 2'd3, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 1'b1), // R3 SP kept
        mk(4'd5, 8'h91, 8'hE6, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0), // R5 other nibble
        mk(4'd2, 8'h00, 8'h4C, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0)  // R2 one-operand group
    };

    function automatic logic [14:0] actual();
        return {out_mode, out_index, out_wreg_y, out_indirect, out_ptr_a16,
                out_opnd, out_len, out_alu_vld};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset strobe", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // vector table; operand bytes are prefix-valued to expose bad skipping (R9)
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [7:0]  pre;
            logic [7:0]  op;
            logic [14:0] ex;
            {rq, pre, op, ex} = VEC[i];
            if (pre != 8'h00) begin
                send(pre);
                check("R11 no strobe on prefix", 32'(out_valid), 32'd0);
            end
            send(op);
            total++;
            if (!(out_valid === 1'b1 && out_illegal === 1'b0 && actual() === ex)) begin
                bad++;
                $display("FAIL R%0d op %h%h actual=%h/%b expected=%h/1", rq, pre, op,
                         actual(), out_valid, ex);
            end
            if (ex[0]) check("R2 operation field", 32'(out_alu_op), 32'(op[3:0]));
            for (int k = 0; k < int'(ex[6:4]); k++) begin
                send(8'h72);
                check("R9 operand byte skipped", 32'(out_valid), 32'd0);
            end
            if (ex[6:4] == 3'd0) begin
                @(posedge clk);
                #1;
                check("R11 single-cycle strobe", 32'(out_valid), 32'd0);
            end
        end

        // R10: two prefixes in a row, then resynchronise
        send(8'h72);
        send(8'h90);
        check("R10 illegal record", {out_valid, out_illegal, out_len, out_opnd, out_mode, out_alu_vld},
              {1'b1, 1'b1, 3'd2, 3'd0, 3'd0, 1'b0});
        send(8'hA6);
        check("R10 resync decode", {out_valid, out_illegal, out_mode, out_len},
              {1'b1, 1'b0, 3'd2, 3'd2});
        send(8'h00);

        // R9: prefix-looking bytes with in_valid low are ignored
        @(negedge clk);
        in_byte = 8'h92;
        repeat (4) @(posedge clk);
        #1;
        check("R9 idle byte no strobe", 32'(out_valid), 32'd0);
        send(8'hC6);
        check("R9 idle prefix ignored", {out_valid, out_mode, out_indirect, out_len},
              {1'b1, 3'd4, 1'b0, 3'd3});
        send(8'h00);
        send(8'h00);

        // R11: reset between a prefix and its opcode drops the prefix
        send(8'h92);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11 reset strobe low", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        send(8'hD6);
        check("R11 prefix cleared by reset", {out_valid, out_mode, out_index, out_indirect, out_len},
              {1'b1, 3'd5, 2'd1, 1'b0, 3'd3});

        finish_run();
    end

endmodule